// File: doc/BRIEF.md
# Register Bank with Read-Count Watermark

This block is a small bank of software-visible registers behind a single-cycle synchronous bus. Writes land in the addressed register at the clock edge. Reads return their data one cycle later, marked by a valid strobe. On top of that ordinary path sits a deliberate fingerprint. A counter tallies read transactions since the last access to one designated guard register. The read that brings the tally to a fixed limit comes back with a chosen set of data bits flipped.

A driver that knows the limit and the flip pattern can track the tally itself and undo the flip. It can also reset the tally at will by touching the guard register. A copy built only from bus traces sees nothing unusual: the timing is standard and only one read in many differs. A copy that returns true data on every read therefore breaks software that expects the flipped read. Every width, the register count, the guard address, the limit and the flip pattern are parameters.

Top module: `read_watermark`

## Requirements
- R1: After a synchronous active-high reset, every register reads as zero, `rsp_valid` is low, `rsp_data` is zero, and the read tally is zero.
- R2: A write stores `bus_wdata` in the addressed register. A later read of that address returns the stored value on `rsp_data` in the cycle after the read strobe is sampled.
- R3: Each read of any address other than the guard address (default 7) adds one to the tally. A write to any address other than the guard address leaves the tally unchanged.
- R4: A read that is not a guard-register read and that brings the tally to THRESHOLD (default 10000) returns the register contents XOR MARK_MASK (default 0x21, which flips data bits 0 and 5).
- R5: After a flipped read the tally is zero. Only that one read is flipped, and the next flipped read is THRESHOLD reads later.
- R6: A read of the guard register returns its true contents, even at tally THRESHOLD-1, and sets the tally to zero. The next ordinary read then counts as read one.
- R7: A write to the guard register sets the tally to zero.
- R8: When read and write strobes are both high in one cycle, the write takes effect and the read returns the value held before that write.
- R9: `rsp_valid` is high exactly in the cycle after each sampled read strobe, whether or not the data is flipped.
- R10: A read of an address at or above NUM_REGS (default 12) returns zero and still counts toward the tally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_data | output | DATA_W (32) | Read data, held between reads |

## Verification
Each read result is due exactly one cycle after the rising edge that samples the read strobe. Write effects and tally changes take hold at that same sampling edge. The bench changes strobes just after a rising edge and pushes the expected word into a queue before the sampling edge. A monitor pops the queue only at the falling edge in which `rsp_valid` is high, so every comparison lands in the cycle the result is due. A count of valid responses against reads issued, together with an empty queue at the end, covers the one-cycle rule without depending on the order of processes at the edge.

// File: rtl/rwm_pkg.sv
package rwm_pkg;

   typedef struct packed {
      logic rd;       // read sampled this cycle
      logic wr;       // write sampled this cycle
      logic guard;    // address is the guard register
   } rwm_access_t;

   function automatic int unsigned rwm_cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/rwm_regfile.sv
module rwm_regfile #(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata_raw
);
   localparam int unsigned SPAN = 1 << ADDR_W;

   logic [DATA_W-1:0] regs_q [NUM_REGS];

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)
            regs_q[gi] <= '0;
         else if (wr_en && (addr == ADDR_W'(gi)))
            regs_q[gi] <= wdata;
      end
   end

   if (NUM_REGS == SPAN) begin : g_full_decode
      assign rdata_raw = regs_q[addr];
   end else begin : g_partial_decode
      always_comb begin
         rdata_raw = '0;
         for (int i = 0; i < NUM_REGS; i++)
            if (addr == ADDR_W'(i)) rdata_raw = regs_q[i];
      end
   end
endmodule

// File: rtl/rwm_counter.sv
module rwm_counter
   import rwm_pkg::*;
#(
   parameter int unsigned THRESHOLD = 10000,
   parameter int unsigned CNT_W     = rwm_cnt_width(THRESHOLD)
) (
   input  logic             clk,
   input  logic             rst,
   input  rwm_access_t      acc,
   output logic             mark_hit,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(THRESHOLD - 1);

   logic [CNT_W-1:0] cnt_q;

   assign mark_hit = acc.rd && !acc.guard && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if ((acc.rd || acc.wr) && acc.guard)
         cnt_q <= '0;
      else if (acc.rd)
         cnt_q <= mark_hit ? '0 : cnt_q + CNT_W'(1);
   end

   assign count = cnt_q;
endmodule

// File: rtl/rwm_outstage.sv
module rwm_outstage #(
   parameter int unsigned        DATA_W    = 32,
   parameter logic [DATA_W-1:0]  MARK_MASK = 'h21
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic              flip,
   input  logic [DATA_W-1:0] raw,
   output logic              valid,
   output logic [DATA_W-1:0] data
);
   logic              valid_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= rd_en;
         if (rd_en)
            data_q <= flip ? (raw ^ MARK_MASK) : raw;
      end
   end

   assign valid = valid_q;
   assign data  = data_q;
endmodule

// File: rtl/read_watermark.sv
module read_watermark
   import rwm_pkg::*;
#(
   parameter int unsigned        ADDR_W    = 4,
   parameter int unsigned        DATA_W    = 32,
   parameter int unsigned        NUM_REGS  = 12,
   parameter int unsigned        GUARD_IDX = 7,
   parameter int unsigned        THRESHOLD = 10000,
   parameter logic [DATA_W-1:0]  MARK_MASK = 'h21
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);
   localparam int unsigned CNT_W = rwm_cnt_width(THRESHOLD);

   if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
      $error("read_watermark: NUM_REGS must be 1..2**ADDR_W");
   end
   if (GUARD_IDX >= NUM_REGS) begin : g_bad_guard
      $error("read_watermark: GUARD_IDX outside register bank");
   end
   if (THRESHOLD < 2) begin : g_bad_limit
      $error("read_watermark: THRESHOLD must be at least 2");
   end
   if (MARK_MASK == '0) begin : g_bad_mask
      $error("read_watermark: MARK_MASK must flip at least one bit");
   end

   rwm_access_t       acc;
   logic              mark_hit;
   logic [CNT_W-1:0]  rd_count;
   logic [DATA_W-1:0] raw_data;

   assign acc.rd    = bus_rd;
   assign acc.wr    = bus_wr;
   assign acc.guard = (bus_addr == ADDR_W'(GUARD_IDX));

   rwm_regfile #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (bus_wr),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .rdata_raw (raw_data)
   );

   rwm_counter #(
      .THRESHOLD (THRESHOLD),
      .CNT_W     (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .acc      (acc),
      .mark_hit (mark_hit),
      .count    (rd_count)
   );

   rwm_outstage #(
      .DATA_W    (DATA_W),
      .MARK_MASK (MARK_MASK)
   ) u_out (
      .clk   (clk),
      .rst   (rst),
      .rd_en (bus_rd),
      .flip  (mark_hit),
      .raw   (raw_data),
      .valid (rsp_valid),
      .data  (rsp_data)
   );
endmodule

// File: rtl/read_watermark_chk.sv
module read_watermark_chk #(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned GUARD_IDX = 7,
   parameter int unsigned THRESHOLD = 10000,
   parameter int unsigned CNT_W     = 14
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic              rsp_valid,
   input logic [CNT_W-1:0]  cnt
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(THRESHOLD - 1);

   logic is_guard;
   assign is_guard = (bus_addr == ADDR_W'(GUARD_IDX));

   AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
      bus_rd |=> rsp_valid);                                              // R9
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
      !bus_rd |=> !rsp_valid);                                            // R9
   AST_GUARD_CLEARS: assert property (@(posedge clk) disable iff (rst)
      ((bus_rd || bus_wr) && is_guard) |=> (cnt == '0));                  // R6
   AST_GUARD_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && !bus_rd && is_guard) |=> (cnt == '0));                   // R7
   AST_WRITE_HOLDS_TALLY: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && !bus_rd && !is_guard) |=> $stable(cnt));                 // R3
   AST_READ_ADVANCES: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && !is_guard && cnt != LAST) |=> (cnt == $past(cnt) + CNT_W'(1))); // R3
   AST_TALLY_WRAPS: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && !is_guard && cnt == LAST) |=> (cnt == '0));              // R5
   AST_TALLY_RANGE: assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST);                                                       // R5
endmodule

bind read_watermark read_watermark_chk #(
   .ADDR_W    (ADDR_W),
   .GUARD_IDX (GUARD_IDX),
   .THRESHOLD (THRESHOLD),
   .CNT_W     (CNT_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .rsp_valid (rsp_valid),
   .cnt       (rd_count)
);

// File: tb/read_watermark_tb.sv
module read_watermark_tb;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 32;
   localparam int NREGS  = 12;
   localparam int GUARD  = 7;
   localparam int LIMIT  = 10000;
   localparam logic [31:0] MASK = 32'h21;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_rd = 1'b0;
   logic              bus_wr = 1'b0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic              rsp_valid;
   logic [DATA_W-1:0] rsp_data;

   always #5 clk = ~clk;

   read_watermark u_dut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   int checks = 0;
   int fails  = 0;
   int reads_issued = 0;
   int valids_seen  = 0;
   int tally = 0;
   logic [31:0] mregs [NREGS];
   logic [31:0] exp_q [$];
   string       tag_q [$];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model_read(input int a);
      logic [31:0] v;
      v = (a < NREGS) ? mregs[a] : 32'h0;
      if (a == GUARD) tally = 0;
      else begin
         tally++;
         if (tally == LIMIT) begin
            v = v ^ MASK;
            tally = 0;
         end
      end
      return v;
   endfunction

   task automatic do_read(input int a, input string req);
      exp_q.push_back(model_read(a));
      tag_q.push_back(req);
      reads_issued++;
      bus_addr = ADDR_W'(a); bus_rd = 1'b1; bus_wr = 1'b0;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic do_write(input int a, input logic [31:0] d);
      if (a == GUARD) tally = 0;
      if (a < NREGS) mregs[a] = d;
      bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic do_rdwr(input int a, input logic [31:0] d, input string req);
      exp_q.push_back(model_read(a));
      tag_q.push_back(req);
      reads_issued++;
      if (a < NREGS) mregs[a] = d;
      bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b1;
      @(posedge clk); #1;
      bus_rd = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bulk(input int n, input string req);
      for (int k = 0; k < n; k++) do_read(k % 6, req);
   endtask

   // monitor: compare each response in the cycle it is due
   always @(negedge clk) begin
      if (!rst && rsp_valid) begin
         valids_seen++;
         if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R9 actual=unexpected response expected=none");
         end else begin
            string t;
            logic [31:0] e;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, rsp_data, e);
         end
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #3_000_000;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < NREGS; i++) mregs[i] = 32'h0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      check("R1 valid", {31'h0, rsp_valid}, 32'h0);
      check("R1 data", rsp_data, 32'h0);
      @(posedge clk); #1;
      for (int i = 0; i < NREGS; i++) do_read(i, "R1");   // includes guard: tally 0 after it
      // R2 write/readback
      for (int i = 0; i < NREGS; i++) do_write(i, 32'hA5000000 + 32'(i * 32'h1111));
      for (int i = 0; i < NREGS; i++) do_read(i, "R2");
      do_write(3, 32'hFFFFFFFF); do_read(3, "R2");
      do_write(3, 32'h00000000); do_read(3, "R2");
      // R10 out of range
      do_read(12, "R10"); do_read(15, "R10");
      // R3/R4: clear, reads with interleaved writes, flip on the limit
      do_read(GUARD, "R6");
      bulk(LIMIT - 2, "R3");
      do_write(2, 32'h12345678); do_write(4, 32'hCAFEF00D);
      do_read(1, "R3");
      do_read(2, "R4");
      // R5: next read true, and exactly LIMIT later another flip
      do_read(4, "R5");
      bulk(LIMIT - 2, "R5");
      do_read(5, "R5");
      do_read(5, "R5");
      // R7: guard write mid-stream clears
      bulk(5000, "R7");
      do_write(GUARD, 32'h0BADBEEF);
      bulk(LIMIT - 1, "R7");
      do_read(0, "R7");
      // R6: guard read at tally LIMIT-1 is true and restarts the tally
      bulk(LIMIT - 1, "R6");
      do_read(GUARD, "R6");
      do_read(1, "R6");
      bulk(LIMIT - 2, "R6");
      do_read(3, "R6");
      // R8: same-cycle read and write
      do_rdwr(9, 32'h55AA55AA, "R8");
      do_read(9, "R8");
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9 responses", 32'(valids_seen), 32'(reads_issued));
      check("R9 queue", 32'(exp_q.size()), 32'h0);
      finish_run();
   end
endmodule